// File: doc/BRIEF.md
# Ping-Pong Audio Sample Player

This block buffers audio between a fast producer that writes one byte at a time and a slow playback clock that consumes one 16-bit sample per tick. A 2 KiB memory is split into two halves used as a ping-pong pair. The producer writes bytes on its own clock. The reader walks through the samples in order and reports which half it is in, so the producer can refill the idle half while playback goes on.

Playback is started with `play` and stopped with `halt`. A small step input sets how many samples the read index moves per playback tick. The index runs over the whole memory and wraps from the last sample back to the first without a gap. While playback is stopped the sample output is zero.

Top module: `pingpong_player`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en` high, byte `wr_data` is stored at byte address `wr_addr`. Sample N takes its low byte from address 2N and its high byte from address 2N+1, which gives 1024 samples. A write with `wr_en` low changes nothing.
- R2: When `play` is high and `halt` is low at a rising `clk` edge, `playing` is high after that edge.
- R3: A sample is presented one `clk` edge after playback starts. In the cycle where `playing` first rises, `sample` is still zero.
- R4: Each `clk` edge that sees `playing` high fetches the sample at the read index and then advances the index by `step`, modulo 1024. A step of 0 repeats the same sample.
- R5: `read_half` is 1 while the read index lies in 512..1023 and 0 while it lies in 0..511.
- R6: The index wraps from 1023 to 0 with no missing or repeated sample.
- R7: `halt` high at an edge clears `playing` after that edge. That edge still completes its fetch and advance. While stopped the index holds, and the next start resumes from it.
- R8: `sample` is zero whenever `playing` is low.
- R9: Reset clears `playing`, sets the read index to 0 (so `read_half` is 0) and sets `sample` to zero.
- R10: When `play` and `halt` are high in the same cycle, `halt` wins and `playing` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Playback clock, one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset of the playback side |
| play | input | 1 | Start playback |
| halt | input | 1 | Stop playback; has priority over play |
| step | input | STEP_W | Samples advanced per playback tick |
| wr_clk | input | 1 | Producer write clock |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 11 | Byte address |
| wr_data | input | 8 | Byte data |
| read_half | output | 1 | Half of the memory holding the current read index |
| playing | output | 1 | Playback active |
| sample | output | 16 | Current sample, zero when not playing |

## Verification
Two things can land on the same playback edge.

The first is a start request and a stop request. The bench drives `play` and `halt` together on one edge and expects `playing` low and `sample` zero afterwards.

The second is a stop and a final fetch-and-advance. Every halt is issued while playback is running. The model advances the index one extra step for that edge, and the next run's first sample shows whether the design did the same.

Stepped runs also cross the 1023-to-0 wrap after the producer has rewritten the lower half. A disabled write is placed on a sample that is later played.

// File: rtl/pingpong_player.sv
`timescale 1ns/1ps
module pingpong_player #(
  parameter int BYTES  = 2048,
  parameter int BYTE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          play,
  input  logic                          halt,
  input  logic [STEP_W-1:0]             step,
  input  logic                          wr_clk,
  input  logic                          wr_en,
  input  logic [$clog2(BYTES)-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic                          read_half,
  output logic                          playing,
  output logic [2*BYTE_W-1:0]           sample
);
  localparam int NSAMP = BYTES / 2;
  localparam int IDX_W = $clog2(NSAMP);

  logic [BYTE_W-1:0]   lo_mem [NSAMP];
  logic [BYTE_W-1:0]   hi_mem [NSAMP];
  logic [IDX_W-1:0]    idx;
  logic [2*BYTE_W-1:0] rd_q;

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      if (wr_addr[0]) hi_mem[wr_addr[IDX_W:1]] <= wr_data;
      else            lo_mem[wr_addr[IDX_W:1]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      playing <= 1'b0;
      idx     <= '0;
      rd_q    <= '0;
    end else begin
      if (halt)      playing <= 1'b0;
      else if (play) playing <= 1'b1;
      if (playing) begin
        rd_q <= {hi_mem[idx], lo_mem[idx]};
        idx  <= idx + {{(IDX_W-STEP_W){1'b0}}, step};
      end else begin
        rd_q <= '0;
      end
    end
  end

  assign read_half = idx[IDX_W-1];
  assign sample    = playing ? rd_q : '0;

  // R2
  play_start_chk: assert property (@(posedge clk) disable iff (rst)
    (play && !halt) |=> playing);

  // R10
  halt_prio_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !playing);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !playing |=> $stable(idx));

  // R4
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (playing && $past(!rst)) |=> (idx - $past(idx)) == IDX_W'($past(step)));

  // R3
  first_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(playing) |-> sample == '0);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!playing && idx == '0 && sample == '0));
endmodule

// File: tb/pingpong_player_test.sv
`timescale 1ns/1ps
module pingpong_player_test;
  logic        clk = 0, rst = 1, play = 0, halt = 0;
  logic [3:0]  step = 1;
  logic        wr_clk = 0, wr_en = 0;
  logic [10:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic        read_half, playing;
  logic [15:0] sample;

  pingpong_player uut (.clk(clk), .rst(rst), .play(play), .halt(halt), .step(step),
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_half(read_half), .playing(playing), .sample(sample));

  always #4 clk = ~clk;
  always #1 wr_clk = ~wr_clk;

  logic [15:0] model [1024];
  logic [15:0] q[$];
  int midx = 0, n_cmp = 0, n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int n, logic [15:0] seed);
    return 16'(n * 40503) ^ seed;
  endfunction

  task automatic put(int n, logic [15:0] v, bit en);
    @(negedge wr_clk);
    wr_en = en; wr_addr = {n[9:0], 1'b0}; wr_data = v[7:0];
    @(negedge wr_clk);
    wr_addr[0] = 1'b1; wr_data = v[15:8];
    @(negedge wr_clk);
    wr_en = 0;
    if (en) model[n] = v;
  endtask

  // driver: queue expected samples for a run, then halt it
  task automatic run(int spd, int n);
    @(negedge clk);
    step = spd[3:0]; play = 1; halt = 0;
    q.push_back(16'h0);
    for (int k = 0; k < n; k++) q.push_back(model[(midx + k*spd) % 1024]);
    @(posedge clk); #1 play = 0;
    check("R2 playing after play", {31'b0, playing}, 1);
    wait (q.size() == 0);
    @(negedge clk); halt = 1; q.push_back(16'h0);
    @(posedge clk); #1 halt = 0;
    check("R7 playing after halt", {31'b0, playing}, 0);
    midx = (midx + (n + 1) * spd) % 1024;
    wait (q.size() == 0); #1;
    check("R5 read_half", {31'b0, read_half}, {31'b0, midx >= 512});
  endtask

  // monitor: compare one expected sample per playback edge
  initial begin
    logic [15:0] e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check("R1/R3/R4/R6/R8 sample", {16'b0, sample}, {16'b0, e});
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) put(i, pat(i, 16'h5A3C), 1);
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;
    check("R9 playing", {31'b0, playing}, 0);
    check("R9 sample", {16'b0, sample}, 0);
    check("R9 read_half", {31'b0, read_half}, 0);

    run(1, 20);
    run(0, 4);
    run(3, 30);
    run(15, 30);
    check("R5 upper half", {31'b0, read_half}, 1);
    run(1, 5);

    // refill idle lower half, disabled write on a sample about to play
    for (int i = 0; i < 512; i++) put(i, pat(i, 16'hC3A1), 1);
    put(592, 16'hDEAD, 0);
    run(7, 80);
    check("R6 wrapped index low half", {31'b0, read_half}, 0);

    // R10: play and halt together
    @(negedge clk); play = 1; halt = 1;
    @(posedge clk); #1;
    check("R10 collision playing", {31'b0, playing}, 0);
    check("R8 idle sample", {16'b0, sample}, 0);
    @(negedge clk); play = 0; halt = 0;

    run(15, 58);
    run(1, 20);
    check("R6 index after wrap", midx, 10);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule